// File: doc/BRIEF.md
# Inter-Packet Gap Pacer

This block sits in a 64-bit packet stream. It holds packets in a small beat buffer and releases them so that the start of each packet follows the start of the one before by a programmed number of clock cycles. Each packet carries its own spacing value. The value travels in the user sideband of that packet's final beat, in the field that starts at bit 25. The value sets how long the next packet must wait after this packet's first beat went out. When a start cannot happen on time, the block sends the packet as early as it can and does not drop it. It also sets a sticky warning. A start can be late for two reasons: the packet itself is longer than its gap, or the sink holds off a start that is already due.

Both stream edges use valid/ready. A beat moves on a clock edge where valid and ready are both high. The input side drops ready while the buffer holds `DEPTH` beats. On the output side, while a beat is offered and ready stays low, the data, keep and last fields do not change. Valid does not fall either, except when `active` drops before a new packet's first beat has gone out. A low `active` stops new packets from starting. A packet that has already started always finishes. The `warn_clear` pin acts as the write to a software clear register. It returns the warning bit to zero.

Top module: `ipg_pacer`

## Requirements
- R1: While reset is held, `m_valid` is 0, `warn` is 0 and `s_ready` is 1.
- R2: The gap G is the unsigned field `s_user[GAP_LSB+GAP_W-1:GAP_LSB]`, where GAP_LSB = 25, taken from a packet's last beat. The next packet's first beat never goes out fewer than G cycles after this packet's first beat did.
- R3: Take a packet of L beats. If G >= L, the sink stays ready and the next packet is already buffered, then the next first beat goes out exactly G cycles after this packet's first beat. With G = L the packets go back-to-back, and in these cases no warning is raised.
- R4: If G < L (this includes G = 0 with a one-beat packet), the next packet starts on the cycle after the last beat, which is L cycles after the first beat. The warning is set.
- R5: Suppose the next packet's first beat is offered, its gap has elapsed, `active` is high and `m_ready` is low. The warning is then set. The packet is sent once ready returns and is not dropped.
- R6: A sink stall that ends before the gap has elapsed leaves the spacing at exactly G and raises no warning.
- R7: While `active` is low, no new packet starts and `m_valid` stays 0 between packets. Buffered packets wait and leave after `active` rises.
- R8: Bits 24:0 of the last-beat user field (a 24-bit latency value and a flag at bit 24) have no effect on spacing. The user field of non-last beats has no effect either.
- R9: `warn` is 1 from the cycle after a late event until the cycle after a `warn_clear` pulse. If a clear and a late event fall in the same cycle, the clear wins.
- R10: Data, keep and last leave in the order they entered and are not changed. The user field is not forwarded.
- R11: `s_ready` is 0 while `DEPTH` beats are buffered.
- R12: While `m_valid` is high and `m_ready` is low, the offered data stays stable. Valid stays high unless `active` is low at a packet start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| active | input | 1 | Enables new packet starts |
| warn_clear | input | 1 | One-cycle pulse that clears the warning |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted |
| s_data | input | DATA_W | Input beat data |
| s_keep | input | DATA_W/8 | Input byte enables |
| s_last | input | 1 | Input last beat of packet |
| s_user | input | 25+GAP_W | Sideband; gap field at bit 25 up, read on the last beat only |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Sink ready |
| m_data | output | DATA_W | Output beat data |
| m_keep | output | DATA_W/8 | Output byte enables |
| m_last | output | 1 | Output last beat of packet |
| warn | output | 1 | Sticky status bit 0: a start was late |

## Verification
On every cycle, the assertions check the following:
- No first beat leaves before its gap counter has reached the stored gap.
- A stalled offer keeps its data.
- Every late event shows up on `warn` one cycle later.
- The warning holds until cleared and drops after a clear.
- The buffer never passes its depth and never takes a write while full.

Only the bench scenarios can show the following:
- The exact start-to-start spacing for long, short and zero gaps.
- That the low sideband bits do not matter.
- That a short stall before the due cycle is harmless while a stall across it warns and still delivers the packet.
- That `active` holds a loaded buffer back.

// File: rtl/ipg_pacer_pkg.sv
package ipg_pacer_pkg;
  // width of the latency value that shares the sideband with the gap
  localparam int LAT_W   = 24;
  // gap field begins just above the latency value and its flag bit
  localparam int GAP_LSB = LAT_W + 1;

  typedef enum logic {
    PH_START = 1'b0,  // head of buffer is a packet's first beat
    PH_BODY  = 1'b1   // a packet is part-way out
  } phase_e;
endpackage

// File: rtl/ipg_fifo.sv
module ipg_fifo #(
  parameter int W     = 97,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_pop,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_CNT = (AW + 1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [AW:0]   count_q;
  logic          wr_en, rd_en;

  assign in_ready  = (count_q != FULL_CNT);
  assign out_valid = (count_q != '0);
  assign out_data  = mem[rd_ptr];
  assign wr_en     = in_valid && in_ready;
  assign rd_en     = out_pop && out_valid;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_nxt;
      if (rd_en) rd_ptr <= rd_nxt;
      case ({wr_en, rd_en})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R11: occupancy never exceeds the depth
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL_CNT);

  // R11: a full buffer with no pop takes no new beat
  p_full_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == FULL_CNT) && !out_pop |=> $stable(wr_ptr));
endmodule

// File: rtl/ipg_sched.sv
module ipg_sched
  import ipg_pacer_pkg::*;
#(
  parameter int GAP_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             head_valid,
  input  logic             head_last,
  input  logic [GAP_W-1:0] head_gap,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             pop,
  output logic             late
);
  phase_e           phase_q;
  logic [GAP_W-1:0] cnt_q;
  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] elapsed;
  logic             due, xfer, first, late_len, late_stall;

  assign due       = (cnt_q >= gap_q);
  assign out_valid = head_valid && ((phase_q == PH_BODY) || (active && due));
  assign xfer      = out_valid && out_ready;
  assign first     = xfer && (phase_q == PH_START);
  assign pop       = xfer;

  // cycles since the current packet's first beat; zero on that beat itself
  assign elapsed    = (phase_q == PH_BODY) ? cnt_q : '0;
  // next start would fall after its due cycle: packet outlasts its gap
  assign late_len   = xfer && head_last && (head_gap <= elapsed);
  // a due start is offered but the sink holds it off
  assign late_stall = (phase_q == PH_START) && head_valid && active && due && !out_ready;
  assign late       = late_len || late_stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_START;
      cnt_q   <= '0;
      gap_q   <= '0;
    end else begin
      if (first)               cnt_q <= GAP_W'(1);
      else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
      if (xfer) begin
        phase_q <= head_last ? PH_START : PH_BODY;
        if (head_last) gap_q <= head_gap;
      end
    end
  end

  // R2: a first beat leaves only once the previous gap has elapsed
  p_start_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && (phase_q == PH_START) |-> cnt_q >= gap_q);
endmodule

// File: rtl/ipg_warn.sv
module ipg_warn (
  input  logic clk,
  input  logic rst_n,
  input  logic late,
  input  logic clr,
  output logic warn
);
  logic warn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    warn_q <= 1'b0;
    else if (clr)  warn_q <= 1'b0;
    else if (late) warn_q <= 1'b1;
  end

  assign warn = warn_q;

  // R9: the bit holds until cleared
  p_warn_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    warn_q && !clr |=> warn_q);

  // R9: a clear always lands
  p_warn_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !warn_q);
endmodule

// File: rtl/ipg_pacer.sv
module ipg_pacer
  import ipg_pacer_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int GAP_W  = 24,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       active,
  input  logic                       warn_clear,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic [DATA_W-1:0]          s_data,
  input  logic [DATA_W/8-1:0]        s_keep,
  input  logic                       s_last,
  input  logic [GAP_LSB+GAP_W-1:0]   s_user,
  output logic                       m_valid,
  input  logic                       m_ready,
  output logic [DATA_W-1:0]          m_data,
  output logic [DATA_W/8-1:0]        m_keep,
  output logic                       m_last,
  output logic                       warn
);
  localparam int KEEP_W = DATA_W / 8;
  localparam int ENT_W  = DATA_W + KEEP_W + 1 + GAP_W;

  logic [ENT_W-1:0] ent_in, ent_out;
  logic             head_valid, pop, late;
  logic [GAP_W-1:0] in_gap, head_gap;
  logic             head_last;
  logic             unused_user_low;

  // only the gap field is kept; the latency value and its flag are dropped
  assign in_gap          = s_user[GAP_LSB +: GAP_W];
  assign unused_user_low = ^s_user[GAP_LSB-1:0];
  assign ent_in          = {s_data, s_keep, s_last, in_gap};

  ipg_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s_valid),
    .in_ready  (s_ready),
    .in_data   (ent_in),
    .out_valid (head_valid),
    .out_pop   (pop),
    .out_data  (ent_out)
  );

  assign {m_data, m_keep, head_last, head_gap} = ent_out;
  assign m_last = head_last;

  ipg_sched #(.GAP_W(GAP_W)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .head_valid (head_valid),
    .head_last  (head_last),
    .head_gap   (head_gap),
    .out_ready  (m_ready),
    .out_valid  (m_valid),
    .pop        (pop),
    .late       (late)
  );

  ipg_warn u_warn (
    .clk   (clk),
    .rst_n (rst_n),
    .late  (late),
    .clr   (warn_clear),
    .warn  (warn)
  );

  // R12: a stalled offer keeps its data; valid only falls at an inactive start
  p_valid_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> (m_valid || !active) && $stable(m_data) && $stable(m_last));

  // R5: every late event reaches the status bit unless a clear is present
  p_late_sets_warn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    late && !warn_clear |=> warn);
endmodule

// File: tb/sim_ipg_pacer.sv
`timescale 1ns/1ps
module sim_ipg_pacer;
  localparam int DATA_W = 64;
  localparam int GAP_W  = 24;
  localparam int DEPTH  = 16;
  localparam int USER_W = 25 + GAP_W;

  // vector table: packet length, its gap, expected start spacing, expected warn
  localparam int VN = 8;
  localparam int VLEN [VN] = '{4, 4, 4,  1, 1, 12, 12,  6};
  localparam int VGAP [VN] = '{4, 3, 10, 0, 1, 12, 11, 20};
  localparam int VSP  [VN] = '{4, 4, 10, 1, 1, 12, 12, 20};
  localparam int VWRN [VN] = '{0, 1, 0,  1, 0, 0,  1,  0};

  logic clk = 0, rst_n = 0, active = 0, warn_clear = 0;
  logic s_valid = 0, s_last = 0, m_ready = 1;
  logic [DATA_W-1:0] s_data = '0;
  logic [7:0] s_keep = '0;
  logic [USER_W-1:0] s_user = '0;
  logic s_ready, m_valid, m_last, warn;
  logic [DATA_W-1:0] m_data;
  logic [7:0] m_keep;

  int checks = 0, errors = 0, sent = 0, n_starts = 0, mon_beat = 0;
  longint cyc = 0;
  longint start_at [64];
  bit finished = 0;

  ipg_pacer #(.DATA_W(DATA_W), .GAP_W(GAP_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .active(active), .warn_clear(warn_clear),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_keep(s_keep),
    .s_last(s_last), .s_user(s_user), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_keep(m_keep), .m_last(m_last), .warn(warn));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // output monitor: data word = {serial, length, beat index}
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      automatic int beat = int'(m_data[15:0]);
      automatic int len  = int'(m_data[31:16]);
      automatic int ser  = int'(m_data[63:32]);
      if (mon_beat == 0) begin
        start_at[n_starts] = cyc;
        chk(ser == n_starts, "R10 packet order", ser, n_starts);
        n_starts++;
      end
      chk(beat == mon_beat, "R10 beat order", beat, mon_beat);
      chk(m_last == (beat == len - 1), "R10 last flag", m_last, beat == len - 1);
      chk(m_keep == (m_last ? 8'h3F : 8'hFF), "R10 keep", m_keep, m_last ? 8'h3F : 8'hFF);
      mon_beat = m_last ? 0 : mon_beat + 1;
    end
  end

  task automatic send_pkt(input int len, input int gap, input int low, input logic [USER_W-1:0] junk);
    for (int b = 0; b < len; b++) begin
      automatic bit ok;
      s_valid = 1;
      s_data  = {32'(sent), 16'(len), 16'(b)};
      s_last  = (b == len - 1);
      s_keep  = s_last ? 8'h3F : 8'hFF;
      s_user  = s_last ? {GAP_W'(gap), 25'(low)} : junk;
      do begin
        @(negedge clk); ok = s_ready;
        @(posedge clk); #1;
      end while (!ok);
    end
    s_valid = 0; s_last = 0; s_user = '0;
    sent++;
  endtask

  task automatic wait_starts(input int n);
    while (n_starts < n) begin
      @(negedge clk); #2;
    end
  endtask

  task automatic pulse_clear();
    @(posedge clk); #1 warn_clear = 1;
    @(posedge clk); #1 warn_clear = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_starts, sent);
    finish_up();
  end

  initial begin
    int a;
    repeat (3) @(negedge clk);
    chk(m_valid == 0, "R1 m_valid in reset", m_valid, 0);
    chk(warn == 0, "R1 warn in reset", warn, 0);
    chk(s_ready == 1, "R1 s_ready in reset", s_ready, 1);
    @(posedge clk); #1 rst_n = 1;

    // R2 R3 R4 R8: table walk; low sideband bits and non-last user set to junk
    for (int i = 0; i < VN; i++) begin
      pulse_clear();
      if (i == 0) chk(warn == 0, "R9 cleared", warn, 0);
      a = sent;
      send_pkt(VLEN[i], VGAP[i], 25'h1ABCDEF ^ i, {GAP_W'(2), 25'h1FFFFFF});
      send_pkt(1, 1, 0, '0);
      repeat (3) begin
        @(negedge clk);
        chk(m_valid == 0, "R7 held while inactive", m_valid, 0);
      end
      @(posedge clk); #1 active = 1;
      wait_starts(a + 2);
      @(posedge clk); #1 active = 0;
      repeat (2) @(negedge clk);
      chk(start_at[a+1] - start_at[a] == VSP[i],
          VWRN[i] ? "R4 R8 late spacing" : "R2 R3 R8 spacing",
          start_at[a+1] - start_at[a], VSP[i]);
      chk(warn == VWRN[i], VWRN[i] ? "R4 warn set" : "R3 no warn", warn, VWRN[i]);
    end

    // R6: stall that ends before the due cycle
    @(posedge clk); #1;
    pulse_clear();
    a = sent;
    send_pkt(1, 8, 0, '0);
    send_pkt(1, 1, 0, '0);
    @(posedge clk); #1 active = 1;
    wait_starts(a + 1);
    @(posedge clk); #1 m_ready = 0;
    repeat (3) @(posedge clk);
    #1 m_ready = 1;
    wait_starts(a + 2);
    @(posedge clk); #1 active = 0;
    repeat (2) @(negedge clk);
    chk(start_at[a+1] - start_at[a] == 8, "R6 spacing", start_at[a+1] - start_at[a], 8);
    chk(warn == 0, "R6 no warn", warn, 0);

    // R5: stall across the due cycle; packet still delivered
    @(posedge clk); #1;
    a = sent;
    send_pkt(1, 4, 0, '0);
    send_pkt(1, 1, 0, '0);
    @(posedge clk); #1 active = 1;
    wait_starts(a + 1);
    @(posedge clk); #1 m_ready = 0;
    repeat (8) @(posedge clk);
    #1 m_ready = 1;
    wait_starts(a + 2);
    @(posedge clk); #1 active = 0;
    repeat (2) @(negedge clk);
    chk(start_at[a+1] - start_at[a] == 9, "R5 late start sent", start_at[a+1] - start_at[a], 9);
    chk(warn == 1, "R5 warn set", warn, 1);

    // R9: sticky until cleared
    repeat (10) @(negedge clk);
    chk(warn == 1, "R9 sticky", warn, 1);
    @(posedge clk); #1;
    pulse_clear();
    @(negedge clk);
    chk(warn == 0, "R9 clear", warn, 0);

    // R11: full buffer back-pressures the source
    @(posedge clk); #1;
    a = sent;
    send_pkt(DEPTH, DEPTH, 0, '0);
    @(negedge clk);
    chk(s_ready == 0, "R11 full", s_ready, 0);
    chk(m_valid == 0, "R7 buffer held", m_valid, 0);
    @(posedge clk); #1 active = 1;
    wait_starts(a + 1);
    repeat (DEPTH + 4) @(negedge clk);
    chk(s_ready == 1, "R11 drained", s_ready, 1);
    chk(n_starts == sent, "R7 released after active", n_starts, sent);
    chk(warn == 0, "R3 no warn full packet", warn, 0);
    finish_up();
  end
endmodule